// File: doc/BRIEF.md
# Peripheral DMA Request Handshake Engine

This block moves endpoint bytes between a packet buffer and an external DMA controller over a request/acknowledge pin pair. Software arms a transfer with a byte count and a set of configuration inputs. The engine then raises the request pin whenever the buffer side has bytes to offer (or room to take them). Each clock cycle in which the acknowledge pin sits at its active level while the request is up moves exactly one byte. In the read direction a byte is popped from the buffer and handed to the DMA data lane. In the write direction the DMA lane is captured into the buffer.

The packet engine is modelled only by a load strobe. The strobe carries the byte count of the packet now in the buffer and a flag that marks it as short (or empty). The transfer ends on either of two selectable sources: the transfer count running out, or the last byte of a short packet (or an empty packet) in the read direction. When it ends, the request drops, a one-cycle end pulse fires, and a done flag holds until the next arm. Both pins have a programmable active level. Single-cycle mode gives one byte per request. Burst mode holds the request for up to 16 back-to-back bytes.

Top module: `pdma_handshake`

## Requirements
- R1: During and right after a synchronous reset, the request pin is at its inactive level, and `done`, `eot`, both buffer strobes and `xfer_left` are zero.
- R2: The request pin is active high when `cfg_req_pol`=1 and active low when 0. The acknowledge pin is active high when `cfg_ack_pol`=1 and active low when 0.
- R3: In single-cycle mode (`cfg_burst`=0), an accepted byte drops the request for at least one cycle. The request returns in the following cycle if the buffer still holds bytes and the transfer has not ended.
- R4: In burst mode, the request stays up over consecutive accepted bytes. It drops after `cfg_burst_len`+1 bytes (field 0..15 meaning 1..16), or after the buffer's last byte, then returns one cycle later if data remains.
- R5: With `cfg_dir_wr`=0 (buffer to memory), each accepted byte pulses `buf_rd_stb` on the next cycle, and `dma_rdata` holds the `buf_rdata` present in the accept cycle. With `cfg_dir_wr`=1, `buf_wr_stb` pulses instead, and `buf_wdata` holds the `dma_wdata` of the accept cycle.
- R6: With `cfg_eot_cnt_en`=1, the byte that brings `xfer_left` to zero ends the transfer. On the next cycle `eot` is high for one cycle, `done` is high, and the request is inactive. Arming with a count of zero ends the transfer one cycle after the arm.
- R7: With `cfg_eot_short_en`=1 and the read direction, the last byte of a packet loaded with `pkt_short`=1 ends the transfer as in R6. A packet loaded with length zero and `pkt_short`=1 ends the transfer without moving a byte.
- R8: While `done` is high, acknowledges move nothing, the request stays inactive and `xfer_left` holds, until `arm` clears `done` and the transfer resumes.
- R9: An acknowledge while the request is inactive moves no byte.
- R10: `pkt_valid` loads a packet only when the buffer count is zero, and is ignored otherwise. With a zero count and no end condition, the request stays inactive and no end-of-transfer occurs.
- R11: `xfer_left` is loaded by `arm` and falls by one per accepted byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| arm | input | 1 | Starts a transfer, loads `xfer_count`, clears `done` |
| cfg_dir_wr | input | 1 | 0: buffer to memory, 1: memory to buffer |
| cfg_burst | input | 1 | 0: single-cycle, 1: burst |
| cfg_burst_len | input | 4 | Burst length minus one |
| cfg_req_pol | input | 1 | Active level of the request pin |
| cfg_ack_pol | input | 1 | Active level of the acknowledge pin |
| cfg_eot_cnt_en | input | 1 | Enables the count-reached-zero end source |
| cfg_eot_short_en | input | 1 | Enables the short/empty-packet end source |
| xfer_count | input | 16 | Transfer byte count loaded at arm |
| pkt_valid | input | 1 | Packet engine loads a new packet |
| pkt_len | input | 11 | Byte count of the loaded packet |
| pkt_short | input | 1 | Loaded packet is short or empty |
| dreq_pin | output | 1 | DMA request pin (registered) |
| dack_pin | input | 1 | DMA acknowledge pin |
| dma_wdata | input | 8 | Byte from the DMA controller |
| dma_rdata | output | 8 | Byte to the DMA controller |
| buf_rdata | input | 8 | Head byte of the packet buffer |
| buf_rd_stb | output | 1 | Pops one byte from the buffer |
| buf_wr_stb | output | 1 | Pushes `buf_wdata` into the buffer |
| buf_wdata | output | 8 | Byte written into the buffer |
| eot | output | 1 | One-cycle end-of-transfer pulse |
| done | output | 1 | Transfer ended, held until arm |
| xfer_left | output | 16 | Bytes remaining in the transfer |

## Verification
The hardest case to reach is a transfer that pauses because the buffer ran dry mid-burst, then ends on the last byte of a later short packet. Another is what the block does after that end while the DMA keeps acknowledging and the packet engine loads more data. The bench keeps the acknowledge pin active for whole runs. It loads a short first packet, tries a second load that must be ignored, and waits until the request has stayed down. Then it loads a short packet, and after the end pulse it loads yet another packet before re-arming. Every run is logged cycle by cycle from the arm and compared against bit patterns derived from the requirements.

// File: rtl/pdma_pkg.sv
package pdma_pkg;

  // Deepest burst the request may cover.
  localparam int unsigned MAX_BURST = 16;

  // Transfer direction as seen from the packet buffer.
  typedef enum logic {
    DIR_BUF_TO_MEM = 1'b0,
    DIR_MEM_TO_BUF = 1'b1
  } xfer_dir_e;

endpackage

// File: rtl/pdma_pin_io.sv
// Pin-level polarity handling: decodes the acknowledge pin and drives
// the request pin from a register.
module pdma_pin_io (
  input  logic clk,
  input  logic rst,
  input  logic req_pol,
  input  logic ack_pol,
  input  logic dack_pin,
  input  logic req_d,
  output logic ack_act,
  output logic dreq_pin
);

  logic dreq_q;

  assign ack_act  = ack_pol ? dack_pin : ~dack_pin;
  assign dreq_pin = dreq_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      dreq_q <= ~req_pol;
    end else begin
      dreq_q <= req_pol ? req_d : ~req_d;
    end
  end

endmodule

// File: rtl/pdma_counters.sv
// Transfer counter, buffer byte counter, short-packet flag and the
// per-request burst counter.
module pdma_counters #(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned LEN_W = 11,
  parameter int unsigned BL_W  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             arm,
  input  logic [CNT_W-1:0] xfer_count,
  input  logic             pkt_valid,
  input  logic [LEN_W-1:0] pkt_len,
  input  logic             pkt_short,
  input  logic             mv,
  input  logic             burst_clr,
  input  logic             short_clr,
  output logic [CNT_W-1:0] rem,
  output logic [BL_W-1:0]  burst_cnt,
  output logic             short_f,
  output logic             rem_zero,
  output logic             rem_last,
  output logic             avail_zero,
  output logic             avail_last
);

  logic [LEN_W-1:0] avail_q;
  logic             pkt_take;

  assign pkt_take   = pkt_valid && (avail_q == '0);
  assign rem_zero   = (rem == '0);
  assign rem_last   = (rem == CNT_W'(1));
  assign avail_zero = (avail_q == '0);
  assign avail_last = (avail_q == LEN_W'(1));

  // Transfer byte counter, floor at zero.
  always_ff @(posedge clk) begin
    if (rst) begin
      rem <= '0;
    end else if (arm) begin
      rem <= xfer_count;
    end else if (mv && !rem_zero) begin
      rem <= rem - 1'b1;
    end
  end

  // Bytes still in (or room still left in) the current packet.
  always_ff @(posedge clk) begin
    if (rst) begin
      avail_q <= '0;
    end else if (mv) begin
      avail_q <= avail_q - 1'b1;
    end else if (pkt_take) begin
      avail_q <= pkt_len;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      short_f <= 1'b0;
    end else if (pkt_take) begin
      short_f <= pkt_short;
    end else if (short_clr) begin
      short_f <= 1'b0;
    end
  end

  // Bytes moved under the current request assertion.
  always_ff @(posedge clk) begin
    if (rst || burst_clr) begin
      burst_cnt <= '0;
    end else if (mv) begin
      burst_cnt <= burst_cnt + 1'b1;
    end
  end

  // R10
  avail_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    mv |-> !avail_zero);

endmodule

// File: rtl/pdma_req_ctrl.sv
// Request sequencing: decides when the request rises and falls, when a
// byte is accepted, and when the transfer ends.
module pdma_req_ctrl
  import pdma_pkg::*;
#(
  parameter int unsigned BL_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            arm,
  input  xfer_dir_e       dir,
  input  logic            burst_mode,
  input  logic [BL_W-1:0] burst_len,
  input  logic            eot_cnt_en,
  input  logic            eot_short_en,
  input  logic            ack_act,
  input  logic            rem_zero,
  input  logic            rem_last,
  input  logic            avail_zero,
  input  logic            avail_last,
  input  logic            short_f,
  input  logic [BL_W-1:0] burst_cnt,
  output logic            req_d,
  output logic            req_q,
  output logic            mv,
  output logic            short_clr,
  output logic            busy,
  output logic            done,
  output logic            eot
);

  logic short_ok;
  logic burst_last;
  logic eot_mv;
  logic eot_idle;
  logic eot_now;

  assign mv         = busy && req_q && ack_act;
  assign short_ok   = eot_short_en && (dir == DIR_BUF_TO_MEM) && short_f;
  assign burst_last = (burst_cnt == burst_len);

  // End on the byte that empties the count or the short packet.
  assign eot_mv   = mv && ((eot_cnt_en && rem_last) || (short_ok && avail_last));
  // End with no byte: zero count at arm or an empty short packet.
  assign eot_idle = busy && !req_q &&
                    ((eot_cnt_en && rem_zero) || (short_ok && avail_zero));
  assign eot_now  = eot_mv || eot_idle;

  assign short_clr = eot_now && short_ok && (mv ? avail_last : avail_zero);

  always_comb begin
    if (arm || !busy || eot_now) begin
      req_d = 1'b0;
    end else if (req_q) begin
      req_d = !(mv && (!burst_mode || burst_last || avail_last));
    end else begin
      req_d = !avail_zero;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q <= 1'b0;
      busy  <= 1'b0;
      done  <= 1'b0;
      eot   <= 1'b0;
    end else begin
      req_q <= req_d;
      eot   <= eot_now;
      if (arm) begin
        busy <= 1'b1;
        done <= 1'b0;
      end else if (eot_now) begin
        busy <= 1'b0;
        done <= 1'b1;
      end
    end
  end

  // R3
  single_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (mv && !burst_mode) |=> !req_q);

  // R4
  burst_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (req_q && burst_mode && $stable(burst_len)) |-> (burst_cnt <= burst_len));

  // R6
  done_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !req_q);

endmodule

// File: rtl/pdma_datapath.sv
// Byte lanes between the DMA controller and the packet buffer.
module pdma_datapath
  import pdma_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mv,
  input  xfer_dir_e         dir,
  input  logic [DATA_W-1:0] buf_rdata,
  input  logic [DATA_W-1:0] dma_wdata,
  output logic              buf_rd_stb,
  output logic              buf_wr_stb,
  output logic [DATA_W-1:0] buf_wdata,
  output logic [DATA_W-1:0] dma_rdata
);

  always_ff @(posedge clk) begin
    if (rst) begin
      buf_rd_stb <= 1'b0;
      buf_wr_stb <= 1'b0;
      buf_wdata  <= '0;
      dma_rdata  <= '0;
    end else begin
      buf_rd_stb <= mv && (dir == DIR_BUF_TO_MEM);
      buf_wr_stb <= mv && (dir == DIR_MEM_TO_BUF);
      if (mv && (dir == DIR_BUF_TO_MEM)) begin
        dma_rdata <= buf_rdata;
      end
      if (mv && (dir == DIR_MEM_TO_BUF)) begin
        buf_wdata <= dma_wdata;
      end
    end
  end

  // R5
  stb_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({buf_rd_stb, buf_wr_stb}));

endmodule

// File: rtl/pdma_handshake.sv
module pdma_handshake
  import pdma_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned LEN_W  = 11,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned BL_W   = $clog2(MAX_BURST)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              arm,
  input  logic              cfg_dir_wr,
  input  logic              cfg_burst,
  input  logic [BL_W-1:0]   cfg_burst_len,
  input  logic              cfg_req_pol,
  input  logic              cfg_ack_pol,
  input  logic              cfg_eot_cnt_en,
  input  logic              cfg_eot_short_en,
  input  logic [CNT_W-1:0]  xfer_count,
  input  logic              pkt_valid,
  input  logic [LEN_W-1:0]  pkt_len,
  input  logic              pkt_short,
  output logic              dreq_pin,
  input  logic              dack_pin,
  input  logic [DATA_W-1:0] dma_wdata,
  output logic [DATA_W-1:0] dma_rdata,
  input  logic [DATA_W-1:0] buf_rdata,
  output logic              buf_rd_stb,
  output logic              buf_wr_stb,
  output logic [DATA_W-1:0] buf_wdata,
  output logic              eot,
  output logic              done,
  output logic [CNT_W-1:0]  xfer_left
);

  xfer_dir_e       dir;
  logic            ack_act;
  logic            req_d;
  logic            req_q;
  logic            mv;
  logic            short_clr;
  logic            busy;
  logic            short_f;
  logic            rem_zero;
  logic            rem_last;
  logic            avail_zero;
  logic            avail_last;
  logic [BL_W-1:0] burst_cnt;

  assign dir = xfer_dir_e'(cfg_dir_wr);

  pdma_pin_io u_pins (
    .clk      (clk),
    .rst      (rst),
    .req_pol  (cfg_req_pol),
    .ack_pol  (cfg_ack_pol),
    .dack_pin (dack_pin),
    .req_d    (req_d),
    .ack_act  (ack_act),
    .dreq_pin (dreq_pin)
  );

  pdma_counters #(
    .CNT_W (CNT_W),
    .LEN_W (LEN_W),
    .BL_W  (BL_W)
  ) u_cnt (
    .clk        (clk),
    .rst        (rst),
    .arm        (arm),
    .xfer_count (xfer_count),
    .pkt_valid  (pkt_valid),
    .pkt_len    (pkt_len),
    .pkt_short  (pkt_short),
    .mv         (mv),
    .burst_clr  (!req_q),
    .short_clr  (short_clr),
    .rem        (xfer_left),
    .burst_cnt  (burst_cnt),
    .short_f    (short_f),
    .rem_zero   (rem_zero),
    .rem_last   (rem_last),
    .avail_zero (avail_zero),
    .avail_last (avail_last)
  );

  pdma_req_ctrl #(
    .BL_W (BL_W)
  ) u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .arm          (arm),
    .dir          (dir),
    .burst_mode   (cfg_burst),
    .burst_len    (cfg_burst_len),
    .eot_cnt_en   (cfg_eot_cnt_en),
    .eot_short_en (cfg_eot_short_en),
    .ack_act      (ack_act),
    .rem_zero     (rem_zero),
    .rem_last     (rem_last),
    .avail_zero   (avail_zero),
    .avail_last   (avail_last),
    .short_f      (short_f),
    .burst_cnt    (burst_cnt),
    .req_d        (req_d),
    .req_q        (req_q),
    .mv           (mv),
    .short_clr    (short_clr),
    .busy         (busy),
    .done         (done),
    .eot          (eot)
  );

  pdma_datapath #(
    .DATA_W (DATA_W)
  ) u_dp (
    .clk        (clk),
    .rst        (rst),
    .mv         (mv),
    .dir        (dir),
    .buf_rdata  (buf_rdata),
    .dma_wdata  (dma_wdata),
    .buf_rd_stb (buf_rd_stb),
    .buf_wr_stb (buf_wr_stb),
    .buf_wdata  (buf_wdata),
    .dma_rdata  (dma_rdata)
  );

  // R8
  quiet_after_done_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !arm) |=> (!buf_rd_stb && !buf_wr_stb));

endmodule

// File: tb/pdma_handshake_bench.sv
module pdma_handshake_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        arm = 1'b0;
  logic        cfg_dir_wr = 1'b0;
  logic        cfg_burst = 1'b0;
  logic [3:0]  cfg_burst_len = 4'd0;
  logic        cfg_req_pol = 1'b1;
  logic        cfg_ack_pol = 1'b1;
  logic        cfg_eot_cnt_en = 1'b0;
  logic        cfg_eot_short_en = 1'b0;
  logic [15:0] xfer_count = 16'd0;
  logic        pkt_valid = 1'b0;
  logic [10:0] pkt_len = 11'd0;
  logic        pkt_short = 1'b0;
  logic        dreq_pin;
  logic        dack_pin = 1'b0;
  logic [7:0]  dma_wdata = 8'd0;
  logic [7:0]  dma_rdata;
  logic [7:0]  buf_rdata = 8'd0;
  logic        buf_rd_stb;
  logic        buf_wr_stb;
  logic [7:0]  buf_wdata;
  logic        eot;
  logic        done;
  logic [15:0] xfer_left;

  int n_chk = 0;
  int n_bad = 0;

  logic [39:0] lg_rd, lg_wr, lg_rq, lg_eot, lg_done;
  logic [7:0]  lg_rdd [0:39];
  logic [7:0]  lg_wdd [0:39];
  logic [15:0] lg_left [0:39];

  always #2 clk = ~clk;

  pdma_handshake u_pdma_handshake (
    .clk(clk), .rst(rst), .arm(arm), .cfg_dir_wr(cfg_dir_wr),
    .cfg_burst(cfg_burst), .cfg_burst_len(cfg_burst_len),
    .cfg_req_pol(cfg_req_pol), .cfg_ack_pol(cfg_ack_pol),
    .cfg_eot_cnt_en(cfg_eot_cnt_en), .cfg_eot_short_en(cfg_eot_short_en),
    .xfer_count(xfer_count), .pkt_valid(pkt_valid), .pkt_len(pkt_len),
    .pkt_short(pkt_short), .dreq_pin(dreq_pin), .dack_pin(dack_pin),
    .dma_wdata(dma_wdata), .dma_rdata(dma_rdata), .buf_rdata(buf_rdata),
    .buf_rd_stb(buf_rd_stb), .buf_wr_stb(buf_wr_stb), .buf_wdata(buf_wdata),
    .eot(eot), .done(done), .xfer_left(xfer_left)
  );

  task automatic chk(string tag, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    arm = 1'b0; pkt_valid = 1'b0; dack_pin = ~cfg_ack_pol;
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic load_pkt(int len, bit sh);
    @(negedge clk);
    pkt_valid = 1'b1; pkt_len = 11'(len); pkt_short = sh;
    @(negedge clk);
    pkt_valid = 1'b0;
  endtask

  task automatic ack_hold(bit on);
    dack_pin = on ? cfg_ack_pol : ~cfg_ack_pol;
  endtask

  // Sample n negedges; index 0 follows the edge that sees the current
  // arm/pkt_valid drive. Both strobes are released after the first sample.
  task automatic run_log(int n);
    lg_rd = '0; lg_wr = '0; lg_rq = '0; lg_eot = '0; lg_done = '0;
    for (int j = 0; j < n; j++) begin
      @(negedge clk);
      lg_rd[j]   = buf_rd_stb;
      lg_wr[j]   = buf_wr_stb;
      lg_rq[j]   = (dreq_pin == cfg_req_pol);
      lg_eot[j]  = eot;
      lg_done[j] = done;
      lg_rdd[j]  = dma_rdata;
      lg_wdd[j]  = buf_wdata;
      lg_left[j] = xfer_left;
      arm = 1'b0; pkt_valid = 1'b0;
      buf_rdata = 8'hA0 + 8'(j);
      dma_wdata = 8'h50 + 8'(j);
    end
  endtask

  task automatic t_reset();
    cfg_req_pol = 1'b1; cfg_ack_pol = 1'b1;
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    // R1: state under reset
    chk("R1 dreq inactive", dreq_pin, 0);
    chk("R1 done/eot/strobes", {done, eot, buf_rd_stb, buf_wr_stb}, 0);
    chk("R1 xfer_left", xfer_left, 0);
    rst = 1'b0;
  endtask

  task automatic t_single();
    cfg_dir_wr = 1'b0; cfg_burst = 1'b0; cfg_req_pol = 1'b1; cfg_ack_pol = 1'b1;
    cfg_eot_cnt_en = 1'b1; cfg_eot_short_en = 1'b0;
    do_reset();
    load_pkt(8, 1'b0);
    xfer_count = 16'd3; arm = 1'b1; ack_hold(1'b1);
    run_log(16);
    // R3 / R9: one byte per request, gap between bytes
    chk("R3 req pattern", lg_rq[15:0], 16'h002A);
    chk("R9 R5 rd strobes", lg_rd[15:0], 16'h0054);
    chk("R5 no wr strobe", lg_wr[15:0], 0);
    chk("R5 rdata byte1", lg_rdd[2], 8'hA1);
    chk("R5 rdata byte3", lg_rdd[6], 8'hA5);
    // R6: count end
    chk("R6 eot pulse", lg_eot[15:0], 16'h0040);
    chk("R6 done", lg_done[15:0], 16'hFFC0);
    // R11
    chk("R11 left after 1", lg_left[3], 2);
    chk("R11 left at end", lg_left[6], 0);
    ack_hold(1'b0);
  endtask

  task automatic t_burst();
    cfg_dir_wr = 1'b1; cfg_burst = 1'b1; cfg_burst_len = 4'd3;
    cfg_req_pol = 1'b0; cfg_ack_pol = 1'b0;
    cfg_eot_cnt_en = 1'b1; cfg_eot_short_en = 1'b0;
    do_reset();
    // R2: low-active request idles high
    chk("R2 idle pin level", dreq_pin, 1);
    load_pkt(10, 1'b0);
    xfer_count = 16'd6; arm = 1'b1; ack_hold(1'b1);
    run_log(14);
    // R4 / R2 / R9
    chk("R4 R2 req pattern", lg_rq[13:0], 14'h00DE);
    chk("R4 R9 wr strobes", lg_wr[13:0], 14'h01BC);
    chk("R5 no rd strobe", lg_rd[13:0], 0);
    chk("R5 wdata byte1", lg_wdd[2], 8'h51);
    chk("R5 wdata byte5", lg_wdd[7], 8'h56);
    chk("R6 R8 eot pulse", lg_eot[13:0], 14'h0100);
    ack_hold(1'b0);
    cfg_req_pol = 1'b1; cfg_ack_pol = 1'b1;
  endtask

  task automatic t_short();
    cfg_dir_wr = 1'b0; cfg_burst = 1'b1; cfg_burst_len = 4'd15;
    cfg_eot_cnt_en = 1'b1; cfg_eot_short_en = 1'b1;
    do_reset();
    load_pkt(3, 1'b0);
    load_pkt(7, 1'b0);          // R10: ignored, buffer not empty
    xfer_count = 16'd20; arm = 1'b1; ack_hold(1'b1);
    run_log(12);
    chk("R10 R4 rd strobes", lg_rd[11:0], 12'h01C);
    chk("R10 req stays low", lg_rq[11:0], 12'h00E);
    chk("R10 no eot", lg_eot[11:0], 0);
    pkt_valid = 1'b1; pkt_len = 11'd2; pkt_short = 1'b1;
    run_log(8);
    chk("R7 rd strobes", lg_rd[7:0], 8'h0C);
    chk("R7 req", lg_rq[7:0], 8'h06);
    chk("R7 eot", lg_eot[7:0], 8'h08);
    chk("R11 left", lg_left[7], 15);
    // R8: after end, more data and acks move nothing
    pkt_valid = 1'b1; pkt_len = 11'd4; pkt_short = 1'b0;
    run_log(8);
    chk("R8 no strobes", {lg_rd[7:0], lg_wr[7:0]}, 0);
    chk("R8 no req", lg_rq[7:0], 0);
    chk("R8 left holds", lg_left[7], 15);
    chk("R8 done holds", lg_done[7:0], 8'hFF);
    // R8: re-arm resumes
    arm = 1'b1;
    run_log(4);
    chk("R8 rearm clears done", lg_done[0], 0);
    chk("R8 rearm strobes", lg_rd[3:0], 4'hC);
    ack_hold(1'b0);
  endtask

  task automatic t_empty();
    cfg_dir_wr = 1'b0; cfg_burst = 1'b0;
    cfg_eot_cnt_en = 1'b0; cfg_eot_short_en = 1'b1;
    do_reset();
    load_pkt(0, 1'b1);
    xfer_count = 16'd9; arm = 1'b1; ack_hold(1'b1);
    run_log(6);
    chk("R7 empty eot", lg_eot[5:0], 6'h02);
    chk("R7 empty no byte", {lg_rd[5:0], lg_rq[5:0]}, 0);
    ack_hold(1'b0);
  endtask

  task automatic t_zero();
    cfg_dir_wr = 1'b1; cfg_burst = 1'b0;
    cfg_eot_cnt_en = 1'b1; cfg_eot_short_en = 1'b0;
    do_reset();
    load_pkt(5, 1'b0);
    xfer_count = 16'd0; arm = 1'b1; ack_hold(1'b1);
    run_log(6);
    chk("R6 zero count eot", lg_eot[5:0], 6'h02);
    chk("R6 zero count no byte", lg_wr[5:0], 0);
    ack_hold(1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_single();
    t_burst();
    t_short();
    t_empty();
    t_zero();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule